// File: doc/BRIEF.md
# Ring-Buffer Capture Sequencer

This block sequences the writes of an embedded logic analyzer into a circular sample memory of `DEPTH` words. Once the host arms it, it drives a write address and a write strobe toward the sample RAM. In single-shot mode it first keeps a programmable amount of history from before the trigger. It then fills the rest of the ring after the trigger arrives and stops. The trigger comparators, the sample RAM and the host register bus are outside the block and appear only as plain ports.

The host selects a trigger mode and a trigger position, then raises the start request. It polls the state output until it reads the finished code. It then reads the RAM starting at `rd_ptr`, wraps to address 0, and ends just before `rd_ptr`, which gives the samples in time order. A rising edge on the stop request aborts a capture or clears a finished one and returns the block to idle.

Three trigger modes are supported:
- Single-shot: keeps history before the trigger and fills the rest of the ring after it.
- Incremental: stores a sample only while the trigger input is high.
- Immediate: ignores the trigger and stores `DEPTH` consecutive samples.

Top module: `capture_ctrl`

## Requirements
- R1: A synchronous reset forces `state_o` to IDLE (0), `wr_en` low, and `wr_addr` and `rd_ptr` to 0.
- R2: A capture begins only on a 0-to-1 change of `start_req` seen in IDLE. A level held high does not start another capture. A start edge in any state other than IDLE has no effect.
- R3: A 0-to-1 change of `stop_req` returns the block to IDLE on the next clock edge from any state, with `rd_ptr` cleared and `wr_en` low. A stop edge wins over a start edge in the same cycle.
- R4: State codes are IDLE=0, SEEK=1 (filling pre-trigger history), ARMED=2 (waiting for the trigger), RUN=3 (capturing), DONE=4. `wr_en` is high only in SEEK, ARMED and RUN. In SEEK and ARMED it is high on every cycle, and in RUN it is high on every cycle except in incremental mode.
- R5: Each capture writes its first sample at address 0. After each write the address advances by one, modulo `DEPTH`.
- R6: In immediate mode (`mode_sel`=2) the trigger input is ignored. Exactly `DEPTH` consecutive samples are written, the block enters DONE, and `rd_ptr` reads 0.
- R7: In incremental mode (`mode_sel`=1), RUN writes a sample exactly on the cycles where `trig_in` is high. After `DEPTH` writes the block enters DONE with `rd_ptr`=0.
- R8: In single-shot mode (`mode_sel`=0, with 3 treated as 0), the block first writes `trig_loc` samples in SEEK, and `trig_in` is ignored during SEEK. It then writes every cycle in ARMED until a cycle with `trig_in` high; that sample is stored. It then writes `DEPTH`−`trig_loc`−1 further samples, enters DONE, and sets `rd_ptr` to the address after the last write.
- R9: In single-shot mode with `trig_loc`=0, the block enters ARMED directly from IDLE.
- R10: DONE holds without writing, with `rd_ptr` unchanged, until a stop edge.
- R11: `mode_sel` and `trig_loc` are taken when the capture starts. Later changes do not affect that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Combined trigger flag from the comparators |
| mode_sel | input | 2 | Trigger mode: 0 single-shot, 1 incremental, 2 immediate, 3 single-shot |
| trig_loc | input | AW | Number of pre-trigger samples, less than DEPTH |
| start_req | input | 1 | Start request; acts on its rising edge |
| stop_req | input | 1 | Stop request; acts on its rising edge |
| wr_addr | output | AW | Sample RAM write address |
| wr_en | output | 1 | Sample RAM write strobe |
| state_o | output | 3 | Current state code |
| rd_ptr | output | AW | Address of the oldest sample after DONE |

## Verification
The assertions check on every cycle that:
- the write strobe is confined to the three writing states;
- IDLE is left only on a start edge;
- a stop edge always lands in IDLE;
- SEEK never jumps straight past ARMED;
- DONE is sticky with a frozen read pointer;
- the write address steps by exactly one, modulo depth, per write.

Only the bench scenarios can show that each mode writes the right number of samples. The same holds for the final read pointer after a ring wrap, for triggers during SEEK being ignored, and for mode or position changes during a capture having no effect.

// File: rtl/capctl_pkg.sv
`timescale 1ns/1ps
package capctl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SEEK  = 3'd1,
      ST_ARMED = 3'd2,
      ST_RUN   = 3'd3,
      ST_DONE  = 3'd4
   } cap_state_e;

   localparam logic [1:0] MODE_ONESHOT = 2'd0;
   localparam logic [1:0] MODE_STEP    = 2'd1;
   localparam logic [1:0] MODE_FREE    = 2'd2;
endpackage

// File: rtl/capctl_edge.sv
`timescale 1ns/1ps
module capctl_edge #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= d;
   end

   assign rise = d & ~prev_q;

   // R2: an edge lasts one cycle, a held level gives no repeat
   p_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
      (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/capctl_ring_ptr.sv
`timescale 1ns/1ps
module capctl_ring_ptr #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          adv,
   output logic [AW-1:0] ptr,
   output logic [AW-1:0] nxt
);
   localparam bit          POW2 = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (POW2) begin : g_pow2
         assign nxt = ptr + 1'b1;
      end else begin : g_mod
         assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) ptr <= '0;
      else if (adv)   ptr <= nxt;
   end

   // R5: one step per write, wrapping at DEPTH
   p_step_r5: assert property (@(posedge clk) disable iff (rst)
      (adv && !clr) |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
   // R5: every capture starts from address 0
   p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      clr |=> (ptr == '0));
endmodule

// File: rtl/capctl_fsm.sv
`timescale 1ns/1ps
module capctl_fsm
   import capctl_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_rise,
   input  logic          stop_rise,
   input  logic          trig,
   input  logic [1:0]    mode_in,
   input  logic [AW-1:0] loc_in,
   input  logic [AW-1:0] cur_addr,
   input  logic [AW-1:0] nxt_addr,
   output logic [2:0]    state_o,
   output logic          we,
   output logic          clr,
   output logic [AW-1:0] rd_ptr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   initial begin
      assert (DEPTH >= 2) else $error("capctl_fsm: DEPTH must be at least 2");
   end

   cap_state_e    state;
   logic          step_q;
   logic [AW-1:0] loc_q;
   logic [AW-1:0] rem_q;

   assign state_o = state;

   always_comb begin
      case (state)
         ST_SEEK, ST_ARMED: we = 1'b1;
         ST_RUN:            we = step_q ? trig : 1'b1;
         default:           we = 1'b0;
      endcase
   end

   assign clr = stop_rise | ((state == ST_IDLE) & start_rise);

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         step_q <= 1'b0;
         loc_q  <= '0;
         rem_q  <= '0;
         rd_ptr <= '0;
      end else if (stop_rise) begin
         state  <= ST_IDLE;
         rd_ptr <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start_rise) begin
               step_q <= (mode_in == MODE_STEP);
               loc_q  <= loc_in;
               rem_q  <= LAST;
               rd_ptr <= '0;
               if (mode_in == MODE_FREE || mode_in == MODE_STEP) state <= ST_RUN;
               else if (loc_in == '0)                            state <= ST_ARMED;
               else                                              state <= ST_SEEK;
            end
            ST_SEEK: if (cur_addr == loc_q - 1'b1) state <= ST_ARMED;
            ST_ARMED: if (trig) begin
               if (loc_q == LAST) begin
                  state  <= ST_DONE;
                  rd_ptr <= nxt_addr;
               end else begin
                  state <= ST_RUN;
                  rem_q <= LAST - loc_q - 1'b1;
               end
            end
            ST_RUN: if (we) begin
               if (rem_q == '0) begin
                  state  <= ST_DONE;
                  rd_ptr <= nxt_addr;
               end else begin
                  rem_q <= rem_q - 1'b1;
               end
            end
            default: state <= state;
         endcase
      end
   end

   // R2: IDLE is left only on a start edge
   p_idle_wait_r2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && !start_rise) |=> (state == ST_IDLE));
   // R3: a stop edge always lands in IDLE
   p_stop_idle_r3: assert property (@(posedge clk) disable iff (rst)
      stop_rise |=> (state == ST_IDLE && rd_ptr == '0));
   // R10: DONE is sticky with a frozen read pointer
   p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DONE && !stop_rise) |=> (state == ST_DONE && $stable(rd_ptr)));
   // R8: the trigger cannot skip the history fill
   p_seek_order_r8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_SEEK && !stop_rise) |=> (state == ST_SEEK || state == ST_ARMED));
endmodule

// File: rtl/capture_ctrl.sv
`timescale 1ns/1ps
module capture_ctrl
   import capctl_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          trig_in,
   input  logic [1:0]    mode_sel,
   input  logic [AW-1:0] trig_loc,
   input  logic          start_req,
   input  logic          stop_req,
   output logic [AW-1:0] wr_addr,
   output logic          wr_en,
   output logic [2:0]    state_o,
   output logic [AW-1:0] rd_ptr
);
   logic [1:0]    rise_v;
   logic          ptr_clr;
   logic [AW-1:0] nxt_addr;

   capctl_edge #(.W(2)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .d    ({stop_req, start_req}),
      .rise (rise_v)
   );

   capctl_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
      .clk (clk),
      .rst (rst),
      .clr (ptr_clr),
      .adv (wr_en),
      .ptr (wr_addr),
      .nxt (nxt_addr)
   );

   capctl_fsm #(.DEPTH(DEPTH), .AW(AW)) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .start_rise (rise_v[0]),
      .stop_rise  (rise_v[1]),
      .trig       (trig_in),
      .mode_in    (mode_sel),
      .loc_in     (trig_loc),
      .cur_addr   (wr_addr),
      .nxt_addr   (nxt_addr),
      .state_o    (state_o),
      .we         (wr_en),
      .clr        (ptr_clr),
      .rd_ptr     (rd_ptr)
   );

   // R4: the write strobe stays inside the writing states
   p_we_states_r4: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (state_o == 3'd1 || state_o == 3'd2 || state_o == 3'd3));
endmodule

// File: tb/test_capture_ctrl.sv
`timescale 1ns/1ps
module test_capture_ctrl;
   localparam int DEPTH = 8;
   localparam int AW    = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          trig_in = 1'b0;
   logic [1:0]    mode_sel = 2'd0;
   logic [AW-1:0] trig_loc = '0;
   logic          start_req = 1'b0;
   logic          stop_req = 1'b0;
   logic [AW-1:0] wr_addr;
   logic          wr_en;
   logic [2:0]    state_o;
   logic [AW-1:0] rd_ptr;

   always #10 clk = ~clk;

   capture_ctrl #(.DEPTH(DEPTH), .AW(AW)) i_capture_ctrl (
      .clk(clk), .rst(rst), .trig_in(trig_in), .mode_sel(mode_sel),
      .trig_loc(trig_loc), .start_req(start_req), .stop_req(stop_req),
      .wr_addr(wr_addr), .wr_en(wr_en), .state_o(state_o), .rd_ptr(rd_ptr)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic [2:0]  loc;
      logic [31:0] mask;
      logic [5:0]  exp_w;
      logic [5:0]  exp_done;
      logic [2:0]  exp_rd;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{2'd0, 3'd4, 32'h0000_0042, 6'd10, 6'd10, 3'd2},
      '{2'd0, 3'd0, 32'h0000_0008, 6'd11, 6'd11, 3'd3},
      '{2'd0, 3'd7, 32'h0000_0200, 6'd10, 6'd10, 3'd2},
      '{2'd3, 3'd2, 32'h0000_0004, 6'd8,  6'd8,  3'd0},
      '{2'd2, 3'd5, 32'hFFFF_FFFF, 6'd8,  6'd8,  3'd0},
      '{2'd2, 3'd0, 32'h0000_0000, 6'd8,  6'd8,  3'd0},
      '{2'd1, 3'd3, 32'hAAAA_AAAA, 6'd8,  6'd16, 3'd0},
      '{2'd1, 3'd1, 32'h0000_00FF, 6'd8,  6'd8,  3'd0}
   };

   int  n_chk = 0;
   int  n_bad = 0;
   bit  summary_done = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
      $finish;
   endtask

   task automatic stop_pulse();
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
      #1;
      check(state_o == 3'd0, "R3 stop to IDLE", state_o, 0);
      check(rd_ptr == '0, "R3 rd_ptr cleared", rd_ptr, 0);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
   end

   initial begin
      vec_t  v;
      string tag;
      bit    is_step, done, exp_we;
      int    writes, done_k, first_st;
      logic [AW-1:0] held_rd;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check(state_o == 3'd0, "R1 reset state", state_o, 0);
      check(wr_en == 1'b0, "R1 reset wr_en", wr_en, 0);
      check(wr_addr == '0, "R1 reset wr_addr", wr_addr, 0);
      check(rd_ptr == '0, "R1 reset rd_ptr", rd_ptr, 0);

      for (int i = 0; i < 8; i++) begin
         v = VECS[i];
         is_step = (v.mode == 2'd1);
         tag = (v.mode == 2'd2) ? "R6" : (is_step ? "R7" : "R8");
         @(negedge clk);
         mode_sel = v.mode; trig_loc = v.loc; start_req = 1'b1; trig_in = 1'b0;
         @(negedge clk);
         start_req = 1'b0;
         // R11: disturb the settings once the capture has begun
         mode_sel = (v.mode == 2'd2) ? 2'd0 : 2'd2;
         trig_loc = v.loc ^ 3'b101;
         writes = 0; done = 1'b0; done_k = -1; first_st = -1;
         for (int k = 0; k < 40 && !done; k++) begin
            trig_in = (k < 32) ? v.mask[k] : 1'b0;
            #1;
            if (k == 0) first_st = state_o;
            if (state_o == 3'd4) begin
               done = 1'b1; done_k = k;
            end else begin
               check(state_o >= 3'd1 && state_o <= 3'd3, "R4 writing state", state_o, 1);
               exp_we = (is_step && state_o == 3'd3) ? trig_in : 1'b1;
               check(wr_en == exp_we, {tag, " wr_en"}, wr_en, exp_we);
               if (wr_en) begin
                  check(wr_addr == writes[2:0], "R5 address order", wr_addr, writes[2:0]);
                  writes++;
               end
               @(negedge clk);
            end
         end
         check(done, {tag, " reached DONE"}, done, 1);
         check(writes == v.exp_w, {tag, " write count"}, writes, v.exp_w);
         check(rd_ptr == v.exp_rd, {tag, " rd_ptr"}, rd_ptr, v.exp_rd);
         check(done_k == v.exp_done, "R11 capture length", done_k, v.exp_done);
         if (v.mode == 2'd0 || v.mode == 2'd3) begin
            if (v.loc == 3'd0) check(first_st == 2, "R9 straight to ARMED", first_st, 2);
            else               check(first_st == 1, "R8 starts in SEEK", first_st, 1);
         end

         // R10 and R2: DONE holds, ignores trigger and a new start edge
         held_rd = rd_ptr;
         trig_in = 1'b1;
         @(negedge clk); start_req = 1'b1;
         @(negedge clk); start_req = 1'b0;
         for (int h = 0; h < 3; h++) begin
            #1;
            check(state_o == 3'd4, "R10 DONE held", state_o, 4);
            check(wr_en == 1'b0, "R10 no write in DONE", wr_en, 0);
            check(rd_ptr == held_rd, "R2 start ignored, rd_ptr stable", rd_ptr, held_rd);
            @(negedge clk);
         end
         trig_in = 1'b0;
         stop_pulse();
      end

      // R3: abort mid-capture with start and stop together; stop wins
      @(negedge clk); mode_sel = 2'd0; trig_loc = 3'd4; start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
      @(negedge clk);
      #1;
      check(state_o == 3'd1, "R8 SEEK during history", state_o, 1);
      @(negedge clk); stop_req = 1'b1; start_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
      #1;
      check(state_o == 3'd0, "R3 stop beats start", state_o, 0);
      check(wr_en == 1'b0, "R3 no write after stop", wr_en, 0);
      // R2: start held high gives no new capture
      for (int h = 0; h < 3; h++) begin
         @(negedge clk); #1;
         check(state_o == 3'd0, "R2 held start ignored", state_o, 0);
      end
      start_req = 1'b0;

      // R1: synchronous reset in the middle of an immediate capture
      @(negedge clk); mode_sel = 2'd2; start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      #1;
      check(state_o == 3'd0, "R1 reset mid-capture state", state_o, 0);
      check(wr_addr == '0, "R1 reset mid-capture wr_addr", wr_addr, 0);
      check(rd_ptr == '0, "R1 reset mid-capture rd_ptr", rd_ptr, 0);
      check(wr_en == 1'b0, "R1 reset mid-capture wr_en", wr_en, 0);

      summary();
   end
endmodule